// File: doc/BRIEF.md
# Match/Capture Timer Counter

This block is a 32-bit up-counter with four compare channels and four snapshot channels, programmed over a simple word-addressed register bus. The counter advances either once per clock or once per detected edge of an external count input. It wraps from all ones to zero.

Each compare channel watches for equality with its own value register. On a count tick taken while the counter equals that value, the channel may raise a sticky interrupt flag, force the counter back to zero, or stop the counter. The channel also drives one output pin, which it can leave alone, drive low, drive high or invert.

Each snapshot channel passes its input through a two-flop synchronizer and then looks for edges. On a selected edge it copies the counter into its own register and may raise a flag. A single interrupt line is the OR of all flags. Software reads and writes registers with a one-cycle write strobe and a combinational read path.

Top module: `mct_timer`

## Requirements
- R1: After reset the counter reads 0, the run bit (control register at word 0, bit 0) reads 0, all flags (word 5) read 0, all compare outputs are 0 and `irq_o` is 0.
- R2: With control bits [3:2] = 00 and run = 1, the counter (word 1) rises by exactly one per clock cycle. With run = 0 it holds its value.
- R3: Control bits [3:2] pick the external source: 01 counts rising edges of `cnt_in`, 10 counts falling edges and 11 counts both. Each detected edge adds exactly one.
- R4: A tick at 32'hFFFF_FFFF takes the counter to 0.
- R5: Compare settings sit at word 2, three bits per channel c at [3c+2:3c]: bit 3c enables the flag, bit 3c+1 enables clear and bit 3c+2 enables stop. Compare values sit at words 8+c. When clear is enabled, a tick taken while the counter equals the value loads 0 instead of incrementing.
- R6: When stop is enabled, that tick clears the run bit and the counter keeps its value (0 if clear is also enabled). Later ticks are ignored until software sets run again.
- R7: When flag is enabled, that tick sets flag bit c of word 5. With no setting enabled the counter keeps incrementing past the value.
- R8: Output actions sit at word 3, two bits per channel c at [2c+1:2c]: 00 keep, 01 drive low, 10 drive high, 11 invert. The action is applied to `mat_o[c]` on each compare event.
- R9: Snapshot settings sit at word 4, three bits per channel c at [3c+2:3c]: bit 3c is the rising-edge enable, bit 3c+1 the falling-edge enable and bit 3c+2 the flag enable. A selected edge on `cap_in[c]` copies the counter into word 12+c. An edge that is not selected leaves that word unchanged.
- R10: A snapshot taken with the flag enabled sets bit 4+c of word 5.
- R11: Writing a 1 to a flag bit clears it, and writing a 0 leaves it alone. `irq_o` is 1 exactly when any flag is set.
- R12: Control bit 1 holds the counter at 0 while it is set, and overrides bus writes and ticks.
- R13: A write to word 1 loads the counter, and the new value reads back on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cnt_in | input | 1 | External count input |
| cap_in | input | 4 | Snapshot inputs |
| mat_o | output | 4 | Compare outputs |
| irq_o | output | 1 | Interrupt, OR of all flags |

## Verification
The compare logic is tried with every one of the eight clear/stop/flag combinations on every channel. Each run uses six external edges against a value of 3, so the final counts of 6, 3, 2 and 0 show which action fired and whether a stopped counter ignored further ticks. The output actions are applied in a chain (high, keep, invert, invert, low, keep), so each step depends on the level before it, and the other channels' pins must stay low throughout. Snapshot channels see a rising and then a falling edge under all four edge-enable settings, with a different counter value loaded before each edge, so a snapshot taken on the wrong edge reads back as a visibly wrong number. Count-source, wrap and hold-clear runs complete the coverage.

// File: rtl/mct_pkg.sv
package mct_pkg;

    localparam int BUS_W = 32;

    // word addresses
    localparam int A_CTRL   = 0;
    localparam int A_COUNT  = 1;
    localparam int A_MCFG   = 2;
    localparam int A_OCFG   = 3;
    localparam int A_CCFG   = 4;
    localparam int A_FLAGS  = 5;
    localparam int A_PINS   = 6;
    localparam int A_MATCH0 = 8;
    localparam int A_SNAP0  = 12;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'b00,
        SRC_RISE = 2'b01,
        SRC_FALL = 2'b10,
        SRC_BOTH = 2'b11
    } cnt_src_e;

    typedef enum logic [1:0] {
        OUT_KEEP = 2'b00,
        OUT_LOW  = 2'b01,
        OUT_HIGH = 2'b10,
        OUT_FLIP = 2'b11
    } out_act_e;

    typedef struct packed {
        logic stop;
        logic clr;
        logic irq;
    } match_cfg_t;

    typedef struct packed {
        logic irq;
        logic fall;
        logic rise;
    } snap_cfg_t;

    function automatic logic next_pin(input out_act_e a, input logic cur);
        logic r;
        unique case (a)
            OUT_LOW:  r = 1'b0;
            OUT_HIGH: r = 1'b1;
            OUT_FLIP: r = ~cur;
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mct_edge_sync.sv
module mct_edge_sync #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] s1_q, s2_q, s3_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q & ~s3_q;
    assign fall = ~s2_q & s3_q;
endmodule

// File: rtl/mct_match_unit.sv
module mct_match_unit
    import mct_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] count,
    input  logic [CW-1:0] value,
    input  out_act_e      act,
    output logic          fire,
    output logic          pin
);
    assign fire = tick && (count == value);

    always_ff @(posedge clk) begin
        if (rst)       pin <= 1'b0;
        else if (fire) pin <= next_pin(act, pin);
    end
endmodule

// File: rtl/mct_capture_unit.sv
module mct_capture_unit
    import mct_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rise,
    input  logic          fall,
    input  snap_cfg_t     cfg,
    input  logic [CW-1:0] count,
    output logic          hit,
    output logic [CW-1:0] snap
);
    assign hit = (rise && cfg.rise) || (fall && cfg.fall);

    always_ff @(posedge clk) begin
        if (rst)      snap <= '0;
        else if (hit) snap <= count;
    end
endmodule

// File: rtl/mct_timer.sv
module mct_timer
    import mct_pkg::*;
#(
    parameter int CW = 32,
    parameter int NM = 4,
    parameter int NC = 4,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             cnt_in,
    input  logic [NC-1:0]    cap_in,
    output logic [NM-1:0]    mat_o,
    output logic             irq_o
);
    localparam int NF = NM + NC;

    logic          run_q, clr_q;
    cnt_src_e      src_q;
    logic [CW-1:0] count_q;
    match_cfg_t    mcfg_q   [NM];
    out_act_e      oact_q   [NM];
    logic [CW-1:0] mval_q   [NM];
    snap_cfg_t     ccfg_q   [NC];
    logic [CW-1:0] snap_w   [NC];
    logic [NF-1:0] flags_q;

    logic [NC:0]   e_rise, e_fall;
    logic          src_edge, tick;
    logic [NM-1:0] fire, m_irq_en, m_clr_en, m_stop_en;
    logic [NC-1:0] c_hit, c_irq_en;
    logic          rst_hit, stop_hit, ctrl_wr, cnt_wr, flag_wr;
    logic [NF-1:0] flag_set;

    assign ctrl_wr = bus_wr && (bus_addr == AW'(A_CTRL));
    assign cnt_wr  = bus_wr && (bus_addr == AW'(A_COUNT));
    assign flag_wr = bus_wr && (bus_addr == AW'(A_FLAGS));

    // synchronizers: bit 0 is the count input, bits NC:1 the snapshot inputs
    mct_edge_sync #(.N(NC + 1)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  ({cap_in, cnt_in}),
        .rise (e_rise),
        .fall (e_fall)
    );

    always_comb begin
        unique case (src_q)
            SRC_RISE: src_edge = e_rise[0];
            SRC_FALL: src_edge = e_fall[0];
            SRC_BOTH: src_edge = e_rise[0] | e_fall[0];
            default:  src_edge = 1'b1;
        endcase
    end

    assign tick = run_q && src_edge;

    generate
        for (genvar c = 0; c < NM; c++) begin : g_match
            mct_match_unit #(.CW(CW)) mu_i (
                .clk   (clk),
                .rst   (rst),
                .tick  (tick),
                .count (count_q),
                .value (mval_q[c]),
                .act   (oact_q[c]),
                .fire  (fire[c]),
                .pin   (mat_o[c])
            );
            assign m_irq_en[c]  = mcfg_q[c].irq;
            assign m_clr_en[c]  = mcfg_q[c].clr;
            assign m_stop_en[c] = mcfg_q[c].stop;
        end
        for (genvar c = 0; c < NC; c++) begin : g_snap
            mct_capture_unit #(.CW(CW)) cu_i (
                .clk   (clk),
                .rst   (rst),
                .rise  (e_rise[c+1]),
                .fall  (e_fall[c+1]),
                .cfg   (ccfg_q[c]),
                .count (count_q),
                .hit   (c_hit[c]),
                .snap  (snap_w[c])
            );
            assign c_irq_en[c] = ccfg_q[c].irq;
        end
    endgenerate

    assign rst_hit  = |(fire & m_clr_en);
    assign stop_hit = |(fire & m_stop_en);
    assign flag_set = {c_hit & c_irq_en, fire & m_irq_en};

    // counter and control
    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            run_q   <= 1'b0;
            clr_q   <= 1'b0;
            src_q   <= SRC_CLK;
        end else begin
            if (clr_q)          count_q <= '0;
            else if (cnt_wr)    count_q <= CW'(bus_wdata);
            else if (tick) begin
                if (rst_hit)        count_q <= '0;
                else if (!stop_hit) count_q <= count_q + 1'b1;
            end
            if (ctrl_wr) begin
                run_q <= bus_wdata[0];
                clr_q <= bus_wdata[1];
                src_q <= cnt_src_e'(bus_wdata[3:2]);
            end else if (stop_hit) begin
                run_q <= 1'b0;
            end
        end
    end

    // channel configuration and compare values
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NM; c++) begin
                mcfg_q[c] <= '0;
                oact_q[c] <= OUT_KEEP;
                mval_q[c] <= '0;
            end
            for (int c = 0; c < NC; c++) ccfg_q[c] <= '0;
        end else if (bus_wr) begin
            for (int c = 0; c < NM; c++) begin
                if (bus_addr == AW'(A_MCFG))       mcfg_q[c] <= match_cfg_t'(bus_wdata[3*c +: 3]);
                if (bus_addr == AW'(A_OCFG))       oact_q[c] <= out_act_e'(bus_wdata[2*c +: 2]);
                if (bus_addr == AW'(A_MATCH0 + c)) mval_q[c] <= CW'(bus_wdata);
            end
            for (int c = 0; c < NC; c++)
                if (bus_addr == AW'(A_CCFG)) ccfg_q[c] <= snap_cfg_t'(bus_wdata[3*c +: 3]);
        end
    end

    // sticky flags: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (flags_q & ~(flag_wr ? NF'(bus_wdata) : '0)) | flag_set;
    end

    assign irq_o = |flags_q;

    // read path
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(A_CTRL))  bus_rdata[3:0] = {src_q, clr_q, run_q};
        if (bus_addr == AW'(A_COUNT)) bus_rdata = BUS_W'(count_q);
        if (bus_addr == AW'(A_FLAGS)) bus_rdata[NF-1:0] = flags_q;
        if (bus_addr == AW'(A_PINS))  bus_rdata[NM-1:0] = mat_o;
        for (int c = 0; c < NM; c++) begin
            if (bus_addr == AW'(A_MCFG))       bus_rdata[3*c +: 3] = mcfg_q[c];
            if (bus_addr == AW'(A_OCFG))       bus_rdata[2*c +: 2] = oact_q[c];
            if (bus_addr == AW'(A_MATCH0 + c)) bus_rdata = BUS_W'(mval_q[c]);
        end
        for (int c = 0; c < NC; c++) begin
            if (bus_addr == AW'(A_CCFG))      bus_rdata[3*c +: 3] = ccfg_q[c];
            if (bus_addr == AW'(A_SNAP0 + c)) bus_rdata = BUS_W'(snap_w[c]);
        end
    end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
    parameter int CW = 32,
    parameter int NM = 4,
    parameter int NF = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] count_q,
    input logic          run_q,
    input logic          clr_q,
    input logic          tick,
    input logic          rst_hit,
    input logic          stop_hit,
    input logic          cnt_wr,
    input logic          ctrl_wr,
    input logic [NM-1:0] fire,
    input logic [NM-1:0] m_irq_en,
    input logic [NF-1:0] flags_q,
    input logic [1:0]    act0,
    input logic [NM-1:0] mat_o
);
    logic plain_step;
    assign plain_step = tick && !rst_hit && !stop_hit && !clr_q && !cnt_wr;

    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        plain_step |=> count_q == $past(count_q) + 1'b1);

    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (plain_step && (&count_q)) |=> count_q == '0);

    assert_clear_on_match_R5: assert property (@(posedge clk) disable iff (rst)
        (rst_hit && !clr_q && !cnt_wr) |=> count_q == '0);

    assert_stop_clears_run_R6: assert property (@(posedge clk) disable iff (rst)
        (stop_hit && !ctrl_wr) |=> !run_q);

    assert_idle_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !clr_q && !cnt_wr) |=> $stable(count_q));

    assert_flag_on_match_R7: assert property (@(posedge clk) disable iff (rst)
        (|(fire & m_irq_en)) |=> (|flags_q[NM-1:0]));

    assert_flip_pin_R8: assert property (@(posedge clk) disable iff (rst)
        (fire[0] && act0 == 2'b11) |=> mat_o[0] != $past(mat_o[0]));

    assert_high_pin_R8: assert property (@(posedge clk) disable iff (rst)
        (fire[0] && act0 == 2'b10) |=> mat_o[0]);

    assert_hold_zero_R12: assert property (@(posedge clk) disable iff (rst)
        clr_q |=> count_q == '0);
endmodule

bind mct_timer mct_timer_chk #(.CW(CW), .NM(NM), .NF(NM + NC)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .count_q  (count_q),
    .run_q    (run_q),
    .clr_q    (clr_q),
    .tick     (tick),
    .rst_hit  (rst_hit),
    .stop_hit (stop_hit),
    .cnt_wr   (cnt_wr),
    .ctrl_wr  (ctrl_wr),
    .fire     (fire),
    .m_irq_en (m_irq_en),
    .flags_q  (flags_q),
    .act0     (oact_q[0]),
    .mat_o    (mat_o)
);

// File: tb/mct_timer_tb_top.sv
module mct_timer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cnt_in = 1'b0;
    logic [3:0]  cap_in = '0;
    logic [3:0]  mat_o;
    logic        irq_o;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mct_timer dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt_in    (cnt_in),
        .cap_in    (cap_in),
        .mat_o     (mat_o),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); cnt_in = 1'b1;
            repeat (4) @(negedge clk);
            cnt_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, a0, b0;
        logic [31:0] exp_snap [4];
        for (int c = 0; c < 4; c++) exp_snap[c] = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(4'd1, d); check("R1 count", d, 0);
        rd(4'd0, d); check("R1 ctrl", d, 0);
        rd(4'd5, d); check("R1 flags", d, 0);
        check("R1 pins", {28'd0, mat_o}, 0);
        check("R1 irq", {31'd0, irq_o}, 0);

        // R2 internal clock counting
        wr(4'd0, 32'h1);
        rd(4'd1, a0);
        repeat (9) @(negedge clk);
        rd(4'd1, b0);
        check("R2 step per clock", b0 - a0, 32'd10);
        wr(4'd0, 32'h0);
        rd(4'd1, a0);
        repeat (6) @(negedge clk);
        rd(4'd1, b0);
        check("R2 hold when stopped", b0, a0);

        // R12 hold-clear
        wr(4'd0, 32'h3);
        repeat (4) @(negedge clk);
        rd(4'd1, d); check("R12 held at zero", d, 0);
        wr(4'd1, 32'h55);
        rd(4'd1, d); check("R12 write overridden", d, 0);
        wr(4'd0, 32'h0);

        // R13 and R4: load near the top and wrap
        wr(4'd1, 32'hFFFF_FFFE);
        rd(4'd1, d); check("R13 load readback", d, 32'hFFFF_FFFE);
        wr(4'd0, 32'h5);
        pulses(3);
        rd(4'd1, d); check("R4 wrap to zero", d, 32'd1);

        // R3 source encodings
        wr(4'd0, 32'h0); wr(4'd1, 0); wr(4'd0, 32'h9);
        pulses(5);
        rd(4'd1, d); check("R3 falling edges", d, 32'd5);
        wr(4'd0, 32'h0); wr(4'd1, 0); wr(4'd0, 32'hD);
        pulses(5);
        rd(4'd1, d); check("R3 both edges", d, 32'd10);
        wr(4'd0, 32'h0); wr(4'd1, 0); wr(4'd0, 32'h5);
        pulses(3);
        rd(4'd1, d); check("R3 rising edges", d, 32'd3);

        // R5/R6/R7/R11: every compare setting on every channel
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < 8; k++) begin
                logic e_irq, e_clr, e_stop;
                logic [31:0] e_cnt;
                e_irq = k[0]; e_clr = k[1]; e_stop = k[2];
                wr(4'd0, 32'h4);
                for (int m = 0; m < 4; m++)
                    wr(4'(8 + m), (m == c) ? 32'd3 : 32'hFFFF_0000);
                wr(4'd2, 32'(k) << (3 * c));
                wr(4'd5, 32'hFF);
                wr(4'd1, 0);
                wr(4'd0, 32'h5);
                pulses(6);
                if (e_clr)       e_cnt = 0;
                else if (e_stop) e_cnt = 3;
                else             e_cnt = 6;
                if (e_clr && !e_stop) e_cnt = 2;
                rd(4'd1, d);
                if (e_clr)       check("R5 clear on match", d, e_cnt);
                else if (e_stop) check("R6 stop on match", d, e_cnt);
                else             check("R7 runs past value", d, e_cnt);
                rd(4'd0, d); check("R6 run bit", {31'd0, d[0]}, {31'd0, !e_stop});
                rd(4'd5, d); check("R7 flag", d, e_irq ? (32'd1 << c) : 0);
                check("R11 irq line", {31'd0, irq_o}, {31'd0, e_irq});
                if (e_irq) begin
                    wr(4'd5, 32'hFF & ~(32'd1 << c));
                    rd(4'd5, d); check("R11 zero write keeps", d, 32'd1 << c);
                    wr(4'd5, 32'd1 << c);
                    rd(4'd5, d); check("R11 one write clears", d, 0);
                    check("R11 irq drops", {31'd0, irq_o}, 0);
                end
            end
        end
        wr(4'd2, 0);

        // R8 output actions, chained so each depends on the prior level
        for (int c = 0; c < 4; c++) begin
            logic [1:0] acts [6];
            logic lvl;
            acts = '{2'b10, 2'b00, 2'b11, 2'b11, 2'b01, 2'b00};
            lvl = 1'b0;
            wr(4'd0, 32'h4);
            wr(4'd1, 0);
            wr(4'(8 + c), 32'd1);
            wr(4'd2, 32'd2 << (3 * c));
            for (int s = 0; s < 6; s++) begin
                case (acts[s])
                    2'b01:   lvl = 1'b0;
                    2'b10:   lvl = 1'b1;
                    2'b11:   lvl = ~lvl;
                    default: lvl = lvl;
                endcase
                wr(4'd3, 32'(acts[s]) << (2 * c));
                wr(4'd0, 32'h5);
                pulses(2);
                @(negedge clk);
                check("R8 output action", {28'd0, mat_o}, {28'd0, 4'(lvl) << c});
            end
            wr(4'd3, 0);
            wr(4'd2, 0);
            // leave the pin low for later channels
            if (lvl) begin
                wr(4'd3, 32'd1 << (2 * c));
                wr(4'd2, 32'd2 << (3 * c));
                pulses(2);
                wr(4'd3, 0);
                wr(4'd2, 0);
            end
        end
        wr(4'd5, 32'hFF);

        // R9/R10 snapshot edge selection
        for (int c = 0; c < 4; c++) begin
            for (int e = 0; e < 4; e++) begin
                logic en_r, en_f, en_i, any;
                en_r = e[0]; en_f = e[1]; en_i = (e != 3);
                any = 1'b0;
                wr(4'd0, 32'h0);
                wr(4'd4, 32'({en_i, en_f, en_r}) << (3 * c));
                wr(4'd5, 32'hFF);
                wr(4'd1, 32'hA000_0000 + 32'(c * 16 + e * 2));
                @(negedge clk); cap_in[c] = 1'b1;
                repeat (5) @(negedge clk);
                if (en_r) begin exp_snap[c] = 32'hA000_0000 + 32'(c * 16 + e * 2); any = 1'b1; end
                rd(4'(12 + c), d); check("R9 rising snapshot", d, exp_snap[c]);
                wr(4'd1, 32'h5000_0000 + 32'(c * 16 + e * 2 + 1));
                @(negedge clk); cap_in[c] = 1'b0;
                repeat (5) @(negedge clk);
                if (en_f) begin exp_snap[c] = 32'h5000_0000 + 32'(c * 16 + e * 2 + 1); any = 1'b1; end
                rd(4'(12 + c), d); check("R9 falling snapshot", d, exp_snap[c]);
                rd(4'd5, d); check("R10 snapshot flag", d, (en_i && any) ? (32'd1 << (4 + c)) : 0);
            end
            wr(4'd4, 0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule